// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the control and status register bank of a multi-channel DMA engine. Every channel owns two independent register sets, one for the write direction and one for the read direction. Each set holds the channel enable, a start doorbell, a linked-list pointer, a transfer size, source and destination addresses, a control word, a 2-bit encoded channel state, and its own interrupt status, setup and clear registers. It also holds addresses and data for the done and abort message-signalled interrupts, which the block only stores.

Software reaches the bank through a single-cycle 32-bit register port. Writes take effect at the clock edge, and reads return data combinationally for the address presented. The engine side sees one start pulse per set. It reports done and abort events back as one-cycle pulses. Each set drives a level-sensitive local interrupt, computed from its sticky event bits and its enables.

Top module: `dma_chan_regbank`

## Requirements
- R1: A set's byte address is channel*0x200 + direction*0x100 + offset, with direction 0 = write and 1 = read. These registers read back what was written, and the bits not listed read zero: enable (0x00, bit 0), list pointer low and high (0x10, 0x14), size (0x1C), source low and high (0x20, 0x24), destination low and high (0x28, 0x2C), control1 (0x34, bit 0 selects linked-list mode), interrupt setup (0x88, bits 0 and 2..6), done message address (0x90, 0x94), abort message address (0xA0, 0xA4), message data (0xA8).
- R2: After reset every register reads zero, and no start pulse or interrupt is asserted.
- R3: A write of 1 in bit 0 of the doorbell (0x04) to a set whose enable bit 0 is 1 raises that set's start bit for exactly the one cycle after the write. Channel status (0x80, bits [1:0]) reads 1 (running) from that cycle on. The doorbell always reads zero.
- R4: A doorbell write while enable is 0, or with bit 0 clear, gives no start pulse and leaves the status unchanged.
- R5: A done pulse sets the channel status to 3 and an abort pulse sets it to 2. Abort wins when both arrive in the same cycle. Writes to the status register are ignored.
- R6: In interrupt status (0x84), bit 0 is set by a done pulse and bit 2 by an abort pulse. Both bits stay set until cleared.
- R7: Writing 1 to bit 0 or bit 2 of the clear register (0x8C) clears the matching status bit at that edge. An event arriving in the same cycle keeps its bit set. The clear register reads zero.
- R8: A set's local interrupt is high while (status bit 0 and setup bit 4) or (status bit 2 and setup bit 6) holds.
- R9: Offsets with no register (for example 0x08, 0x0C, 0x18, 0x30, 0x98, or any unaligned address) read zero. Writes to them change no register.
- R10: Engine vectors use bit index 2*channel + direction. A write to one set, or an event on one set, changes no other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| engDone | input | 2*NUM_CH | Per-set done event pulse |
| engAbort | input | 2*NUM_CH | Per-set abort event pulse |
| engStart | output | 2*NUM_CH | Per-set start pulse |
| irqLocal | output | 2*NUM_CH | Per-set local interrupt level |

## Verification
The hardest situation to reach is a collision between a software clear and an engine event on the same set in the same cycle. Its mirror case, a simultaneous done and abort that must leave the state at abort, is just as hard. The stimulus reaches both by driving the register write and the engine pulse at the same falling edge. Before that, a seeded random storm of writes across all sixteen sets is checked by a full readback against a shadow model. This shows that no decode path aliases one set or offset onto another.

// File: rtl/dmaRegPkg.sv
package dmaRegPkg;

  typedef enum logic [4:0] {
    RID_NONE, RID_ENABLE, RID_BELL, RID_LIST_LO, RID_LIST_HI, RID_SIZE,
    RID_SRC_LO, RID_SRC_HI, RID_DST_LO, RID_DST_HI, RID_CTRL1, RID_CHSTAT,
    RID_INTSTAT, RID_INTSETUP, RID_INTCLR, RID_MSIDN_LO, RID_MSIDN_HI,
    RID_MSIAB_LO, RID_MSIAB_HI, RID_MSIDATA
  } regId_e;

  typedef struct packed {
    logic   wr;
    regId_e id;
  } regStrobe_t;

  localparam logic [1:0] ST_RUN   = 2'd1;
  localparam logic [1:0] ST_ABORT = 2'd2;
  localparam logic [1:0] ST_DONE  = 2'd3;

  localparam logic [6:0] SETUP_MASK = 7'h7D;
  localparam int BIT_DONE      = 0;
  localparam int BIT_ABORT     = 2;
  localparam int BIT_LSTOP_EN  = 4;
  localparam int BIT_LABORT_EN = 6;

  function automatic regId_e decodeOff(input logic [7:0] off);
    case (off)
      8'h00: return RID_ENABLE;
      8'h04: return RID_BELL;
      8'h10: return RID_LIST_LO;
      8'h14: return RID_LIST_HI;
      8'h1C: return RID_SIZE;
      8'h20: return RID_SRC_LO;
      8'h24: return RID_SRC_HI;
      8'h28: return RID_DST_LO;
      8'h2C: return RID_DST_HI;
      8'h34: return RID_CTRL1;
      8'h80: return RID_CHSTAT;
      8'h84: return RID_INTSTAT;
      8'h88: return RID_INTSETUP;
      8'h8C: return RID_INTCLR;
      8'h90: return RID_MSIDN_LO;
      8'h94: return RID_MSIDN_HI;
      8'hA0: return RID_MSIAB_LO;
      8'hA4: return RID_MSIAB_HI;
      8'hA8: return RID_MSIDATA;
      default: return RID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dmaRegPkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int ADDR_W = 12,
  parameter int NSETS  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb,
  output logic [NSETS-1:0]  setSel
);

  logic [CH_W-1:0] chIdx;
  logic            dirBit;
  logic [7:0]      offset;
  logic [CH_W:0]   setIdx;
  regId_e          idDec;
  logic            chOk;
  logic            hit;

  assign chIdx  = regAddr[ADDR_W-1:9];
  assign dirBit = regAddr[8];
  assign offset = regAddr[7:0];
  assign setIdx = {chIdx, dirBit};
  assign idDec  = decodeOff(offset);

  generate
    if (NUM_CH == (1 << CH_W)) begin : g_fullRange
      assign chOk = 1'b1;
    end else begin : g_partRange
      assign chOk = ({{(32-CH_W){1'b0}}, chIdx} < NUM_CH);
    end
  endgenerate

  assign hit     = chOk && (idDec != RID_NONE);
  assign strb.wr = regWr && hit;
  assign strb.id = hit ? idDec : RID_NONE;

  for (genvar i = 0; i < NSETS; i++) begin : g_sel
    assign setSel[i] = hit && (setIdx == (CH_W+1)'(i));
  end

  // R10: at most one set is addressed per access
  p_one_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(setSel));

  // R9: an unmapped offset selects no set and carries no write
  p_unmapped_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (decodeOff(regAddr[7:0]) == RID_NONE) |-> (setSel == '0 && !strb.wr));

endmodule

// File: rtl/dma_reg_set.sv
module dma_reg_set
  import dmaRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sel,
  input  regStrobe_t  strb,
  input  logic [31:0] wdata,
  input  logic        evDone,
  input  logic        evAbort,
  output logic        startPulse,
  output logic        irqOut,
  output logic [31:0] rdata
);

  logic        enBit, llMode;
  logic [6:0]  setup;
  logic [1:0]  chState;
  logic        stDone, stAbort;
  logic [31:0] listLo, listHi, xferSize, srcLo, srcHi, dstLo, dstHi;
  logic [31:0] msiDnLo, msiDnHi, msiAbLo, msiAbHi, msiData;

  logic wrThis, bellFire, clrHit;

  assign wrThis   = sel && strb.wr;
  assign bellFire = wrThis && (strb.id == RID_BELL) && wdata[0] && enBit;
  assign clrHit   = wrThis && (strb.id == RID_INTCLR);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit <= 1'b0; llMode <= 1'b0; setup <= '0;
      listLo <= '0; listHi <= '0; xferSize <= '0;
      srcLo <= '0; srcHi <= '0; dstLo <= '0; dstHi <= '0;
      msiDnLo <= '0; msiDnHi <= '0; msiAbLo <= '0; msiAbHi <= '0; msiData <= '0;
    end else if (wrThis) begin
      case (strb.id)
        RID_ENABLE:   enBit    <= wdata[0];
        RID_CTRL1:    llMode   <= wdata[0];
        RID_INTSETUP: setup    <= wdata[6:0] & SETUP_MASK;
        RID_LIST_LO:  listLo   <= wdata;
        RID_LIST_HI:  listHi   <= wdata;
        RID_SIZE:     xferSize <= wdata;
        RID_SRC_LO:   srcLo    <= wdata;
        RID_SRC_HI:   srcHi    <= wdata;
        RID_DST_LO:   dstLo    <= wdata;
        RID_DST_HI:   dstHi    <= wdata;
        RID_MSIDN_LO: msiDnLo  <= wdata;
        RID_MSIDN_HI: msiDnHi  <= wdata;
        RID_MSIAB_LO: msiAbLo  <= wdata;
        RID_MSIAB_HI: msiAbHi  <= wdata;
        RID_MSIDATA:  msiData  <= wdata;
        default: ;
      endcase
    end
  end

  // channel state and start pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      chState    <= 2'd0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= bellFire;
      if (evAbort)       chState <= ST_ABORT;
      else if (evDone)   chState <= ST_DONE;
      else if (bellFire) chState <= ST_RUN;
    end
  end

  // sticky event bits, new event beats a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stDone  <= 1'b0;
      stAbort <= 1'b0;
    end else begin
      stDone  <= evDone  || (stDone  && !(clrHit && wdata[BIT_DONE]));
      stAbort <= evAbort || (stAbort && !(clrHit && wdata[BIT_ABORT]));
    end
  end

  assign irqOut = (stDone && setup[BIT_LSTOP_EN]) || (stAbort && setup[BIT_LABORT_EN]);

  always_comb begin
    case (strb.id)
      RID_ENABLE:   rdata = {31'd0, enBit};
      RID_CTRL1:    rdata = {31'd0, llMode};
      RID_INTSETUP: rdata = {25'd0, setup};
      RID_CHSTAT:   rdata = {30'd0, chState};
      RID_INTSTAT:  rdata = {29'd0, stAbort, 1'b0, stDone};
      RID_LIST_LO:  rdata = listLo;
      RID_LIST_HI:  rdata = listHi;
      RID_SIZE:     rdata = xferSize;
      RID_SRC_LO:   rdata = srcLo;
      RID_SRC_HI:   rdata = srcHi;
      RID_DST_LO:   rdata = dstLo;
      RID_DST_HI:   rdata = dstHi;
      RID_MSIDN_LO: rdata = msiDnLo;
      RID_MSIDN_HI: rdata = msiDnHi;
      RID_MSIAB_LO: rdata = msiAbLo;
      RID_MSIAB_HI: rdata = msiAbHi;
      RID_MSIDATA:  rdata = msiData;
      default:      rdata = 32'd0;
    endcase
  end

  // R3: a start pulse only follows a cycle in which the set was enabled
  p_start_enabled_r3: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(enBit));

  // R5: abort dominates the reported state
  p_abort_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    evAbort |=> (chState == ST_ABORT));

  p_done_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    (evDone && !evAbort) |=> (chState == ST_DONE));

  // R6: an event is always captured
  p_done_sticks_r6: assert property (@(posedge clk) disable iff (!rstN)
    evDone |=> stDone);

  // R7: a clear without a competing event empties the bit
  p_clear_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    (clrHit && wdata[BIT_DONE] && !evDone) |=> !stDone);

  // R8: the interrupt needs a pending event
  p_irq_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (stDone || stAbort));

endmodule

// File: rtl/dma_chan_regbank.sv
module dma_chan_regbank
  import dmaRegPkg::*;
#(
  parameter  int NUM_CH = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 9,
  localparam int NSETS  = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [NSETS-1:0]  engDone,
  input  logic [NSETS-1:0]  engAbort,
  output logic [NSETS-1:0]  engStart,
  output logic [NSETS-1:0]  irqLocal
);

  regStrobe_t       strb;
  logic [NSETS-1:0] setSel;
  logic [31:0]      setRdata [NSETS];

  dma_reg_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .ADDR_W(ADDR_W), .NSETS(NSETS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .strb(strb), .setSel(setSel)
  );

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    dma_reg_set u_set (
      .clk(clk), .rstN(rstN), .sel(setSel[g]), .strb(strb), .wdata(regWdata),
      .evDone(engDone[g]), .evAbort(engAbort[g]),
      .startPulse(engStart[g]), .irqOut(irqLocal[g]), .rdata(setRdata[g])
    );
  end

  always_comb begin
    regRdata = 32'd0;
    for (int i = 0; i < NSETS; i++)
      if (setSel[i]) regRdata = regRdata | setRdata[i];
  end

endmodule

// File: tb/sim_dma_chan_regbank.sv
module sim_dma_chan_regbank;

  localparam int NSETS = 16;
  localparam int NRW   = 15;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NSETS-1:0] engDone = '0, engAbort = '0, engStart, irqLocal;

  int nChecks = 0, nFail = 0;
  logic [31:0] shadow [NSETS][NRW];

  always #10 clk = ~clk;

  dma_chan_regbank u0 (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .engDone(engDone),
    .engAbort(engAbort), .engStart(engStart), .irqLocal(irqLocal)
  );

  function automatic int offOf(int k);
    case (k)
      0: return 'h00;  1: return 'h10;  2: return 'h14;  3: return 'h1C;
      4: return 'h20;  5: return 'h24;  6: return 'h28;  7: return 'h2C;
      8: return 'h34;  9: return 'h88; 10: return 'h90; 11: return 'h94;
      12: return 'hA0; 13: return 'hA4; default: return 'hA8;
    endcase
  endfunction

  function automatic logic [31:0] maskOf(int k);
    if (k == 0 || k == 8) return 32'h1;
    if (k == 9) return 32'h7D;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [11:0] addrOf(int setNo, int off);
    return 12'((setNo / 2) * 'h200 + (setNo % 2) * 'h100 + off);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  task automatic engEvent(input int idx, input bit d, input bit ab);
    @(negedge clk);
    engDone[idx] = d; engAbort[idx] = ab;
    @(negedge clk);
    engDone = '0; engAbort = '0;
  endtask

  task automatic clearWithEvent(input int idx, input logic [31:0] clr, input bit d, input bit ab);
    @(negedge clk);
    regWr = 1'b1; regAddr = addrOf(idx, 'h8C); regWdata = clr;
    engDone[idx] = d; engAbort[idx] = ab;
    @(negedge clk);
    regWr = 1'b0; engDone = '0; engAbort = '0;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int unsigned seed;
    seed = $urandom(32'd2718);
    for (int s = 0; s < NSETS; s++)
      for (int k = 0; k < NRW; k++) shadow[s][k] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2: reset state
    @(negedge clk);
    chk("R2 start", {16'd0, engStart}, 32'd0);
    chk("R2 irq", {16'd0, irqLocal}, 32'd0);
    rdReg(addrOf(3, 'h80), v); chk("R2 status", v, 32'd0);
    rdReg(addrOf(9, 'h20), v); chk("R2 src", v, 32'd0);
    rdReg(addrOf(14, 'h88), v); chk("R2 setup", v, 32'd0);

    // R1 R10: random writes then full readback
    for (int n = 0; n < 400; n++) begin
      int s, k;
      logic [31:0] d;
      s = int'($urandom_range(NSETS - 1));
      k = int'($urandom_range(NRW - 1));
      d = $urandom;
      wrReg(addrOf(s, offOf(k)), d);
      shadow[s][k] = d & maskOf(k);
    end
    for (int s = 0; s < NSETS; s++)
      for (int k = 0; k < NRW; k++) begin
        rdReg(addrOf(s, offOf(k)), v);
        chk("R1 R10 readback", v, shadow[s][k]);
      end
    chk("R3 no start from config writes", {16'd0, engStart}, 32'd0);

    // R4: doorbell while disabled, and doorbell with bit 0 clear
    wrReg(addrOf(5, 'h00), 32'h0);
    wrReg(addrOf(5, 'h04), 32'h1);
    chk("R4 disabled bell", {16'd0, engStart}, 32'd0);
    rdReg(addrOf(5, 'h80), v); chk("R4 status kept", v, 32'd0);
    wrReg(addrOf(5, 'h00), 32'h1);
    wrReg(addrOf(5, 'h04), 32'h2);
    chk("R4 bell bit0 clear", {16'd0, engStart}, 32'd0);

    // R3: real start
    wrReg(addrOf(5, 'h04), 32'h1);
    chk("R3 start pulse", {16'd0, engStart}, 32'h20);
    @(negedge clk);
    chk("R3 pulse one cycle", {16'd0, engStart}, 32'd0);
    rdReg(addrOf(5, 'h80), v); chk("R3 running", v, 32'd1);
    rdReg(addrOf(5, 'h04), v); chk("R3 bell reads zero", v, 32'd0);

    // R5: status write ignored, then done
    wrReg(addrOf(5, 'h80), 32'h0);
    rdReg(addrOf(5, 'h80), v); chk("R5 status read-only", v, 32'd1);
    wrReg(addrOf(5, 'h88), 32'h0);
    engEvent(5, 1'b1, 1'b0);
    rdReg(addrOf(5, 'h80), v); chk("R5 done state", v, 32'd3);
    rdReg(addrOf(5, 'h84), v); chk("R6 done bit", v, 32'd1);
    chk("R8 masked irq", {31'd0, irqLocal[5]}, 32'd0);
    wrReg(addrOf(5, 'h88), 32'h10);
    chk("R8 stop irq", {31'd0, irqLocal[5]}, 32'd1);

    // R7: plain clear
    wrReg(addrOf(5, 'h8C), 32'h1);
    rdReg(addrOf(5, 'h84), v); chk("R7 cleared", v, 32'd0);
    chk("R8 irq dropped", {31'd0, irqLocal[5]}, 32'd0);
    rdReg(addrOf(5, 'h8C), v); chk("R7 clear reads zero", v, 32'd0);

    // R5 R6: done and abort together
    engEvent(5, 1'b1, 1'b1);
    rdReg(addrOf(5, 'h80), v); chk("R5 abort wins", v, 32'd2);
    rdReg(addrOf(5, 'h84), v); chk("R6 both bits", v, 32'd5);
    wrReg(addrOf(5, 'h88), 32'h40);
    wrReg(addrOf(5, 'h8C), 32'h1);
    rdReg(addrOf(5, 'h84), v); chk("R7 selective clear", v, 32'd4);
    chk("R8 abort irq", {31'd0, irqLocal[5]}, 32'd1);

    // R7: clear colliding with a new abort keeps the bit
    clearWithEvent(5, 32'h4, 1'b0, 1'b1);
    rdReg(addrOf(5, 'h84), v); chk("R7 event beats clear", v, 32'd4);
    clearWithEvent(5, 32'h5, 1'b1, 1'b0);
    rdReg(addrOf(5, 'h84), v); chk("R7 done kept abort cleared", v, 32'd1);

    // R10: neighbour set untouched
    rdReg(addrOf(4, 'h84), v); chk("R10 neighbour status", v, 32'd0);
    rdReg(addrOf(4, 'h80), v); chk("R10 neighbour state", v, 32'd0);
    chk("R10 neighbour irq", {31'd0, irqLocal[4]}, 32'd0);

    // R9: holes read zero and writes go nowhere
    wrReg(addrOf(0, 'h08), 32'hFFFF_FFFF);
    wrReg(addrOf(0, 'h0C), 32'hFFFF_FFFF);
    wrReg(addrOf(0, 'h18), 32'hFFFF_FFFF);
    wrReg(addrOf(0, 'h30), 32'hFFFF_FFFF);
    wrReg(addrOf(0, 'h98), 32'hFFFF_FFFF);
    wrReg(addrOf(0, 'h22), 32'hFFFF_FFFF);
    rdReg(addrOf(0, 'h08), v); chk("R9 hole 08", v, 32'd0);
    rdReg(addrOf(0, 'h30), v); chk("R9 hole 30", v, 32'd0);
    rdReg(addrOf(0, 'h98), v); chk("R9 hole 98", v, 32'd0);
    rdReg(addrOf(0, 'h22), v); chk("R9 unaligned", v, 32'd0);
    for (int k = 0; k < NRW; k++) begin
      rdReg(addrOf(0, offOf(k)), v);
      chk("R9 no alias", v, shadow[0][k]);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule